// File: doc/BRIEF.md
# Full/Empty Tagged Memory Controller

This block is a small data memory in which every word carries a presence tag next to its data. The tag holds a full/empty state bit, an even parity bit over the data, and spare bits. The storage word is 72 bits wide: 64 data bits plus an 8-bit tag. Requesters issue one of four operations: a plain read, a plain write, a synchronizing read or a synchronizing write.

Synchronizing operations give producer/consumer ordering in hardware. A synchronizing write only lands in an empty word and leaves it full. A synchronizing read only takes data from a full word and leaves it empty. When the word is in the wrong state, the request does not complete. It comes back flagged as retry and memory is left untouched, so the requester can try again later. Plain operations bypass the state bit.

A separate debug path reads out the whole tag of any word and can overwrite it. Software uses this path to save and restore presence state.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset every word holds zero data and a zero tag, so it is empty with correct parity. No response is signalled until a request arrives.
- R2: A plain read (op 2'b00) returns the stored data with retry low and leaves the tag unchanged. A plain write (op 2'b01) stores the data and keeps the full/empty bit as it was.
- R3: A synchronizing read (op 2'b10) of a full word returns its data with retry low and clears the full bit (tag bit 0).
- R4: A synchronizing read of an empty word returns retry, and no data or tag changes.
- R5: A synchronizing write (op 2'b11) to an empty word stores the data and sets the full bit.
- R6: A synchronizing write to a full word returns retry and leaves that word's data and tag unchanged.
- R7: Every request produces exactly one response on the clock edge where it is sampled, and no response appears without a request. A retry response carries zero data and no parity error.
- R8: Every write that completes stores tag bit 1 as the XOR of the 64 data bits (even parity). The spare tag bits 7:2 are kept unchanged by every request.
- R9: A completed read whose stored parity bit does not match its data returns the data with rsp_perr high. A matching read returns rsp_perr low.
- R10: dbg_tag shows, one edge after dbg_addr is applied, the tag held by that word before that edge's updates. When dbg_we is high, dbg_wtag replaces the word's tag. If a request writes the tag of the same word in the same cycle, the debug write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 plain read, 01 plain write, 10 sync read, 11 sync write |
| req_addr | input | 4 | Word address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_retry | output | 1 | Request blocked by word state, nothing changed |
| rsp_rdata | output | 64 | Read data, zero for writes and retries |
| rsp_perr | output | 1 | Parity mismatch on the returned data |
| dbg_addr | input | 4 | Word whose tag is read or replaced |
| dbg_we | input | 1 | Replace the tag of dbg_addr |
| dbg_wtag | input | 8 | Tag to store: bit 0 full, bit 1 parity, bits 7:2 spare |
| dbg_tag | output | 8 | Tag of the word addressed one edge earlier |

## Verification
Requests and debug accesses both resolve in one clock. A request held on the inputs before edge k is answered by the response registers after edge k, and its memory update is visible to any request or debug read sampled at edge k+1. The bench drives inputs just after a falling edge and samples results at the next falling edge. Each expected response is queued when its request is driven and popped on the falling edge that follows. Debug tag readouts are compared one falling edge after dbg_addr is driven.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN_RD = 2'b00,
        OP_PLAIN_WR = 2'b01,
        OP_SYNC_RD  = 2'b10,
        OP_SYNC_WR  = 2'b11
    } fe_op_e;

    localparam int TAG_FULL_BIT = 0;
    localparam int TAG_PAR_BIT  = 1;
    localparam int TAG_RSVD     = 2;

endpackage

// File: rtl/fe_access_ctrl.sv
module fe_access_ctrl
    import fe_mem_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 8
) (
    input  logic              valid,
    input  fe_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_data,
    input  logic [TAG_W-1:0]  cur_tag,
    output logic              grant,
    output logic              rd_ret,
    output logic              data_we,
    output logic              tag_we,
    output logic [TAG_W-1:0]  next_tag,
    output logic              perr
);

    logic is_full;
    logic par_ok;

    always_comb begin
        is_full  = cur_tag[TAG_FULL_BIT];
        par_ok   = ((^cur_data) == cur_tag[TAG_PAR_BIT]);
        grant    = 1'b0;
        rd_ret   = 1'b0;
        data_we  = 1'b0;
        tag_we   = 1'b0;
        next_tag = cur_tag;
        if (valid) begin
            unique case (op)
                OP_PLAIN_RD: begin
                    grant  = 1'b1;
                    rd_ret = 1'b1;
                end
                OP_PLAIN_WR: begin
                    grant                 = 1'b1;
                    data_we               = 1'b1;
                    tag_we                = 1'b1;
                    next_tag[TAG_PAR_BIT] = ^wdata;
                end
                OP_SYNC_RD: begin
                    if (is_full) begin
                        grant                  = 1'b1;
                        rd_ret                 = 1'b1;
                        tag_we                 = 1'b1;
                        next_tag[TAG_FULL_BIT] = 1'b0;
                    end
                end
                OP_SYNC_WR: begin
                    if (!is_full) begin
                        grant                  = 1'b1;
                        data_we                = 1'b1;
                        tag_we                 = 1'b1;
                        next_tag[TAG_PAR_BIT]  = ^wdata;
                        next_tag[TAG_FULL_BIT] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        perr = rd_ret && !par_ok;
    end

endmodule

// File: rtl/fe_word_store.sv
module fe_word_store #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data,
    output logic [TAG_W-1:0]  acc_tag,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_we,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_we,
    input  logic [TAG_W-1:0]  dbg_wtag,
    output logic [TAG_W-1:0]  dbg_rtag
);

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [TAG_W-1:0]  tag_d  [DEPTH];

    assign acc_data = data_q[acc_addr];
    assign acc_tag  = tag_q[acc_addr];
    assign dbg_rtag = tag_q[dbg_addr];

    always_comb begin
        data_d = data_q;
        tag_d  = tag_q;
        if (data_we) data_d[acc_addr] = wr_data;
        if (tag_we)  tag_d[acc_addr]  = wr_tag;
        if (dbg_we)  tag_d[dbg_addr]  = dbg_wtag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            data_q <= data_d;
            tag_q  <= tag_d;
        end
    end

    AST_DBG_TAG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_we |=> tag_q[$past(dbg_addr)] == $past(dbg_wtag)); // R10

endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem
    import fe_mem_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 72,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int TAG_W  = WORD_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_perr,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_we,
    input  logic [TAG_W-1:0]  dbg_wtag,
    output logic [TAG_W-1:0]  dbg_tag
);

    typedef struct packed {
        logic              valid;
        logic              retry;
        logic [DATA_W-1:0] rdata;
        logic              perr;
        logic [TAG_W-1:0]  dtag;
    } out_regs_t;

    out_regs_t out_d, out_q;

    fe_op_e            op;
    logic [DATA_W-1:0] st_data;
    logic [TAG_W-1:0]  st_tag;
    logic [TAG_W-1:0]  st_dbg_tag;
    logic              grant, rd_ret, data_we, tag_we, perr;
    logic [TAG_W-1:0]  next_tag;

    assign op = fe_op_e'(req_op);

    fe_access_ctrl #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
        .valid    (req_valid),
        .op       (op),
        .wdata    (req_wdata),
        .cur_data (st_data),
        .cur_tag  (st_tag),
        .grant    (grant),
        .rd_ret   (rd_ret),
        .data_we  (data_we),
        .tag_we   (tag_we),
        .next_tag (next_tag),
        .perr     (perr)
    );

    fe_word_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (req_addr),
        .acc_data (st_data),
        .acc_tag  (st_tag),
        .data_we  (data_we),
        .wr_data  (req_wdata),
        .tag_we   (tag_we),
        .wr_tag   (next_tag),
        .dbg_addr (dbg_addr),
        .dbg_we   (dbg_we),
        .dbg_wtag (dbg_wtag),
        .dbg_rtag (st_dbg_tag)
    );

    always_comb begin
        out_d.valid = req_valid;
        out_d.retry = req_valid && !grant;
        out_d.rdata = rd_ret ? st_data : '0;
        out_d.perr  = perr;
        out_d.dtag  = st_dbg_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid = out_q.valid;
    assign rsp_retry = out_q.retry;
    assign rsp_rdata = out_q.rdata;
    assign rsp_perr  = out_q.perr;
    assign dbg_tag   = out_q.dtag;

    AST_RSP_ONE_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R7
    AST_PLAIN_NEVER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_op[1] |=> !rsp_retry); // R2
    AST_SYNC_RD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && op == OP_SYNC_RD && !st_tag[TAG_FULL_BIT] |=> rsp_retry); // R4
    AST_SYNC_WR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && op == OP_SYNC_WR && st_tag[TAG_FULL_BIT] |=> rsp_retry); // R6
    AST_SYNC_RD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && op == OP_SYNC_RD && st_tag[TAG_FULL_BIT] |=> !rsp_retry); // R3
    AST_RETRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> rsp_rdata == '0 && !rsp_perr); // R7
    AST_SPARE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> next_tag[TAG_W-1:TAG_RSVD] == st_tag[TAG_W-1:TAG_RSVD]); // R8

endmodule

// File: tb/fe_tagged_mem_bench.sv
`timescale 1ns/1ps
module fe_tagged_mem_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [3:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_retry, rsp_perr;
    logic [63:0] rsp_rdata;
    logic [3:0]  dbg_addr = '0;
    logic        dbg_we = 1'b0;
    logic [7:0]  dbg_wtag = '0;
    logic [7:0]  dbg_tag;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_data [16];
    logic [7:0]  m_tag  [16];

    bit          q_retry [$];
    logic [63:0] q_data  [$];
    bit          q_perr  [$];
    string       q_rq    [$];

    always #4 clk = ~clk;

    fe_tagged_mem u_fe_tagged_mem (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
        .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_wtag(dbg_wtag), .dbg_tag(dbg_tag)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops one expected response each time the design answers.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_rq.size() == 0) begin
                check(1'b0, "R7", "response without request", 64'd1, 64'd0);
            end else begin
                automatic bit          e_retry = q_retry.pop_front();
                automatic logic [63:0] e_data  = q_data.pop_front();
                automatic bit          e_perr  = q_perr.pop_front();
                automatic string       rq      = q_rq.pop_front();
                check(rsp_retry === e_retry, rq, "retry", {63'd0, rsp_retry}, {63'd0, e_retry});
                check(rsp_rdata === e_data,  rq, "rdata", rsp_rdata, e_data);
                check(rsp_perr === e_perr,   rq, "perr",  {63'd0, rsp_perr}, {63'd0, e_perr});
            end
        end
    end

    // Driver: computes expected result from the bench model, applies one request.
    task automatic issue(input logic [1:0] op, input logic [3:0] a,
                         input logic [63:0] d, input string rq);
        bit          full = m_tag[a][0];
        bit          e_retry = 1'b0;
        logic [63:0] e_data = '0;
        bit          e_perr = 1'b0;
        case (op)
            2'b00: begin
                e_data = m_data[a];
                e_perr = (^m_data[a]) != m_tag[a][1];
            end
            2'b01: begin
                m_data[a] = d;
                m_tag[a][1] = ^d;
            end
            2'b10: begin
                if (full) begin
                    e_data = m_data[a];
                    e_perr = (^m_data[a]) != m_tag[a][1];
                    m_tag[a][0] = 1'b0;
                end else e_retry = 1'b1;
            end
            default: begin
                if (!full) begin
                    m_data[a] = d;
                    m_tag[a][1] = ^d;
                    m_tag[a][0] = 1'b1;
                end else e_retry = 1'b1;
            end
        endcase
        if (dbg_we) m_tag[dbg_addr] = dbg_wtag;
        q_retry.push_back(e_retry);
        q_data.push_back(e_data);
        q_perr.push_back(e_perr);
        q_rq.push_back(rq);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        dbg_we    = 1'b0;
    endtask

    task automatic dbg_check(input logic [3:0] a, input string rq);
        dbg_addr = a;
        @(negedge clk);
        check(dbg_tag === m_tag[a], rq, "dbg_tag", {56'd0, dbg_tag}, {56'd0, m_tag[a]});
    endtask

    task automatic dbg_write(input logic [3:0] a, input logic [7:0] t);
        dbg_we   = 1'b1;
        dbg_addr = a;
        dbg_wtag = t;
        m_tag[a] = t;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_data[i] = '0;
            m_tag[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid === 1'b0, "R1", "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
        dbg_check(4'd0, "R1");
        dbg_check(4'd15, "R1");
        issue(2'b00, 4'd2, '0, "R1");
        @(negedge clk);

        // R2: plain write keeps the word empty, plain read returns data
        issue(2'b01, 4'd3, 64'hDEAD_BEEF_0123_4567, "R2");
        issue(2'b00, 4'd3, '0, "R2");
        dbg_check(4'd3, "R2");
        // R4: sync read of empty word retries
        issue(2'b10, 4'd3, '0, "R4");
        dbg_check(4'd3, "R4");
        // R5: sync write fills
        issue(2'b11, 4'd3, 64'h0000_1111_2222_3333, "R5");
        dbg_check(4'd3, "R5");
        // R6: sync write to full word retries, data untouched
        issue(2'b11, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        issue(2'b00, 4'd3, '0, "R6");
        dbg_check(4'd3, "R6");
        // R3: sync read consumes, second one retries
        issue(2'b10, 4'd3, '0, "R3");
        issue(2'b10, 4'd3, '0, "R3");
        dbg_check(4'd3, "R3");
        // R2: plain write to a full word keeps it full
        issue(2'b11, 4'd4, 64'h5, "R5");
        issue(2'b01, 4'd4, 64'h7, "R2");
        dbg_check(4'd4, "R2");

        // R3/R5/R7: back-to-back producer then consumer over eight words
        for (int i = 8; i < 16; i++) issue(2'b11, 4'(i), 64'h0101_0101_0101_0101 * 64'(i), "R5");
        for (int i = 8; i < 16; i++) issue(2'b10, 4'(i), '0, "R3");
        issue(2'b10, 4'd8, '0, "R4");

        // R8: spare bits survive writes, parity follows data
        dbg_write(4'd6, 8'hA8);
        issue(2'b01, 4'd6, 64'h0000_0000_0000_0007, "R8");
        dbg_check(4'd6, "R8");
        issue(2'b11, 4'd6, 64'h3, "R8");
        dbg_check(4'd6, "R8");

        // R9: corrupted parity reported on reads
        issue(2'b01, 4'd5, 64'h1, "R9");
        dbg_write(4'd5, 8'h01);
        issue(2'b00, 4'd5, '0, "R9");
        issue(2'b10, 4'd5, '0, "R9");
        issue(2'b00, 4'd6, '0, "R9");

        // R10: restore full state by debug, then collision with a sync read
        dbg_write(4'd9, {6'd0, 1'b0, 1'b1});
        issue(2'b10, 4'd9, '0, "R10");
        issue(2'b11, 4'd7, 64'hCAFE, "R10");
        dbg_we   = 1'b1;
        dbg_addr = 4'd7;
        dbg_wtag = {6'd0, ^64'hCAFE, 1'b1};
        issue(2'b10, 4'd7, '0, "R10");
        dbg_check(4'd7, "R10");
        issue(2'b10, 4'd7, '0, "R10");

        @(negedge clk);
        check(q_rq.size() == 0, "R7", "pending responses", 64'(q_rq.size()), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule